// File: doc/BRIEF.md
# Remote Memory Write Command Parser

This block sits behind a packet receiver and takes one packet character per cycle. Each character is either a data byte or an end marker. An end marker is either a normal end-of-packet or an error end-of-packet. The block walks the header of a remote memory write command. The header carries the target logical address, a protocol identifier, an instruction byte, a key, a variable block of reply-address bytes, the initiator logical address, a two-byte transaction ID, an extended address, a four-byte memory address and a three-byte data length. A header CRC byte closes the header.

The header CRC is checked as the header arrives. When it matches, the block raises a one-cycle strobe that carries the decoded transaction ID, extended address, address and length. It then forwards the data bytes one by one and checks them against the trailing data CRC. It ends each packet with a one-cycle completion pulse and a result code. The block does no memory access and builds no reply. Path-address bytes are expected to have been removed before the first character reaches it.

After a fault is reported mid-packet, the block ignores every further character until the packet's end marker. It then waits for the next packet.

Top module: `wcmd_parser`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `hdr_stb`, `dat_valid` and `pkt_done` are low and `pkt_code` is 0.
- R2: Header byte order is: target address, protocol ID, instruction, key, reply bytes, initiator address, transaction ID (MS, LS), extended address, address (4 bytes, MS first), length (3 bytes, MS first), header CRC. One cycle after a matching header CRC byte is accepted, `hdr_stb` pulses for one cycle. At that pulse `hdr_tid`, `hdr_ext`, `hdr_addr` and `hdr_len` hold the received fields.
- R3: The number of reply-address bytes between the key and the initiator address is 4 times instruction bits [1:0] (0, 4, 8 or 12). Their values are skipped.
- R4: Both CRCs use polynomial x^8+x^2+x+1 (0x07), initial value 0, processed MSB first. The header CRC covers all header bytes before it. On a mismatch, `pkt_done` pulses one cycle after the CRC byte with `pkt_code`=2, and no `hdr_stb` or data follows.
- R5: If the protocol ID byte is not 0x01, `pkt_done` pulses one cycle later with `pkt_code`=1. The block then produces no output until the end marker has passed.
- R6: Each of the `hdr_len` data bytes after the header CRC appears on `dat_byte` with `dat_valid` high one cycle after it is accepted, in order.
- R7: The byte after the last data byte is the data CRC, computed over the data bytes only (0 for zero length). On the following end-of-packet marker, `pkt_done` pulses with `pkt_code`=0 if it matched, or 3 if it did not.
- R8: An error end marker arriving before the packet is complete gives `pkt_code`=5.
- R9: An end-of-packet marker arriving before the header CRC byte, including an empty packet, gives `pkt_code`=4.
- R10: An end-of-packet marker arriving after the header but before the data CRC byte gives `pkt_code`=6.
- R11: A byte arriving after the data CRC byte gives `pkt_code`=7 one cycle later. Further characters up to the end marker are ignored.
- R12: `pkt_done` lasts one cycle per reported packet, and `pkt_code` is 0 whenever `pkt_done` is low. Packets may follow one another with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A character is present this cycle |
| in_data | input | 8 | Byte value when no marker is set |
| in_eop | input | 1 | Character is a normal end-of-packet marker |
| in_eep | input | 1 | Character is an error end-of-packet marker |
| hdr_stb | output | 1 | Header accepted, fields valid this cycle |
| hdr_tid | output | 16 | Transaction ID |
| hdr_ext | output | 8 | Extended address |
| hdr_addr | output | 32 | Memory address |
| hdr_len | output | 24 | Data length in bytes |
| dat_valid | output | 1 | Data byte present |
| dat_byte | output | 8 | Forwarded data byte |
| pkt_done | output | 1 | Packet outcome pulse |
| pkt_code | output | 3 | Outcome code, valid with `pkt_done` |

## Verification
The bound checker checks several properties on every cycle. It checks that every forwarded data byte echoes the byte accepted one cycle earlier and only appears between a header strobe and the next completion. It checks that the header strobe, data valid and completion never coincide, that the result code is 0 outside a completion, and that a successful completion has forwarded exactly the header's length in bytes. Only the bench's scenarios can show that the CRCs are correct and that the reply-address skip follows the instruction bits. The same holds for the choice between the short-header, short-data, excess-data and error-end codes, and for how back-to-back packets are handled. The bench covers these cases with a byte-level reference model that is compared on every clock.

// File: rtl/wcmd_pkg.sv
package wcmd_pkg;

    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  PROTO_ID  = 8'h01;
    localparam logic [7:0]  CRC_POLY  = 8'h07;
    localparam int          TID_W     = 16;
    localparam int          ADDR_W    = 32;
    localparam int          LEN_W     = 24;
    localparam int          FCNT_W    = 4;

    typedef enum logic [2:0] {
        RC_OK         = 3'd0,
        RC_PROTO      = 3'd1,
        RC_HDR_CRC    = 3'd2,
        RC_DAT_CRC    = 3'd3,
        RC_HDR_SHORT  = 3'd4,
        RC_ERR_END    = 3'd5,
        RC_DAT_SHORT  = 3'd6,
        RC_TOO_MUCH   = 3'd7
    } wres_e;

    // header phases come first so that "< PH_HCRC" selects header CRC coverage
    typedef enum logic [3:0] {
        PH_TLA, PH_PID, PH_INS, PH_KEY, PH_RPLY, PH_ILA, PH_TID,
        PH_EXT, PH_ADR, PH_LEN, PH_HCRC, PH_DATA, PH_TAIL, PH_DROP
    } wphase_e;

    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] c;
        c = acc ^ din;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/wcmd_crc.sv
module wcmd_crc
    import wcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst)          crc <= '0;
        else if (en)      crc <= crc8_step(clr ? '0 : crc, din);
        else if (clr)     crc <= '0;
    end
endmodule

// File: rtl/wcmd_field.sv
module wcmd_field
    import wcmd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [W-1:0]      q
);
    generate
        if (W == BYTE_W) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)     q <= '0;
                else if (en) q <= din;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst)     q <= '0;
                else if (en) q <= {q[W-BYTE_W-1:0], din};
            end
        end
    endgenerate
endmodule

// File: rtl/wcmd_parser.sv
module wcmd_parser
    import wcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_eop,
    input  logic        in_eep,
    output logic        hdr_stb,
    output logic [15:0] hdr_tid,
    output logic [7:0]  hdr_ext,
    output logic [31:0] hdr_addr,
    output logic [23:0] hdr_len,
    output logic        dat_valid,
    output logic [7:0]  dat_byte,
    output logic        pkt_done,
    output logic [2:0]  pkt_code
);
    wphase_e            ph;
    logic [FCNT_W-1:0]  fcnt;
    logic [LEN_W-1:0]   rem;
    logic               dcrc_ok;
    logic [BYTE_W-1:0]  hcrc, dcrc;
    logic               byte_in, mark_in;

    assign byte_in = in_valid && !in_eop && !in_eep;
    assign mark_in = in_valid && (in_eop || in_eep);

    wcmd_crc u_hcrc (
        .clk (clk), .rst (rst),
        .clr (byte_in && ph == PH_TLA),
        .en  (byte_in && ph < PH_HCRC),
        .din (in_data), .crc (hcrc)
    );

    wcmd_crc u_dcrc (
        .clk (clk), .rst (rst),
        .clr (byte_in && ph == PH_HCRC),
        .en  (byte_in && ph == PH_DATA && rem != '0),
        .din (in_data), .crc (dcrc)
    );

    wcmd_field #(.W(TID_W)) u_tid (
        .clk (clk), .rst (rst), .en (byte_in && ph == PH_TID), .din (in_data), .q (hdr_tid)
    );
    wcmd_field #(.W(BYTE_W)) u_ext (
        .clk (clk), .rst (rst), .en (byte_in && ph == PH_EXT), .din (in_data), .q (hdr_ext)
    );
    wcmd_field #(.W(ADDR_W)) u_adr (
        .clk (clk), .rst (rst), .en (byte_in && ph == PH_ADR), .din (in_data), .q (hdr_addr)
    );
    wcmd_field #(.W(LEN_W)) u_len (
        .clk (clk), .rst (rst), .en (byte_in && ph == PH_LEN), .din (in_data), .q (hdr_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_TLA;
            fcnt      <= '0;
            rem       <= '0;
            dcrc_ok   <= 1'b0;
            hdr_stb   <= 1'b0;
            dat_valid <= 1'b0;
            dat_byte  <= '0;
            pkt_done  <= 1'b0;
            pkt_code  <= RC_OK;
        end else begin
            hdr_stb   <= 1'b0;
            dat_valid <= 1'b0;
            pkt_done  <= 1'b0;
            pkt_code  <= RC_OK;
            if (mark_in) begin
                ph <= PH_TLA;
                if (ph != PH_DROP) begin
                    pkt_done <= 1'b1;
                    if (in_eep)              pkt_code <= RC_ERR_END;
                    else if (ph == PH_DATA)  pkt_code <= RC_DAT_SHORT;
                    else if (ph == PH_TAIL)  pkt_code <= dcrc_ok ? RC_OK : RC_DAT_CRC;
                    else                     pkt_code <= RC_HDR_SHORT;
                end
            end else if (byte_in) begin
                unique case (ph)
                    PH_TLA:  ph <= PH_PID;
                    PH_PID: begin
                        if (in_data == PROTO_ID) ph <= PH_INS;
                        else begin
                            pkt_done <= 1'b1;
                            pkt_code <= RC_PROTO;
                            ph       <= PH_DROP;
                        end
                    end
                    PH_INS: begin
                        fcnt <= {in_data[1:0], 2'b00};
                        ph   <= PH_KEY;
                    end
                    PH_KEY:  ph <= (fcnt == '0) ? PH_ILA : PH_RPLY;
                    PH_RPLY: begin
                        fcnt <= fcnt - 1'b1;
                        if (fcnt == FCNT_W'(1)) ph <= PH_ILA;
                    end
                    PH_ILA: begin
                        fcnt <= FCNT_W'(TID_W / BYTE_W - 1);
                        ph   <= PH_TID;
                    end
                    PH_TID: begin
                        if (fcnt == '0) ph <= PH_EXT;
                        else            fcnt <= fcnt - 1'b1;
                    end
                    PH_EXT: begin
                        fcnt <= FCNT_W'(ADDR_W / BYTE_W - 1);
                        ph   <= PH_ADR;
                    end
                    PH_ADR: begin
                        if (fcnt == '0) begin
                            fcnt <= FCNT_W'(LEN_W / BYTE_W - 1);
                            ph   <= PH_LEN;
                        end else fcnt <= fcnt - 1'b1;
                    end
                    PH_LEN: begin
                        if (fcnt == '0) ph <= PH_HCRC;
                        else            fcnt <= fcnt - 1'b1;
                    end
                    PH_HCRC: begin
                        if (in_data == hcrc) begin
                            hdr_stb <= 1'b1;
                            rem     <= hdr_len;
                            ph      <= PH_DATA;
                        end else begin
                            pkt_done <= 1'b1;
                            pkt_code <= RC_HDR_CRC;
                            ph       <= PH_DROP;
                        end
                    end
                    PH_DATA: begin
                        if (rem != '0) begin
                            dat_valid <= 1'b1;
                            dat_byte  <= in_data;
                            rem       <= rem - 1'b1;
                        end else begin
                            dcrc_ok <= (in_data == dcrc);
                            ph      <= PH_TAIL;
                        end
                    end
                    PH_TAIL: begin
                        pkt_done <= 1'b1;
                        pkt_code <= RC_TOO_MUCH;
                        ph       <= PH_DROP;
                    end
                    default: ph <= PH_DROP;
                endcase
            end
        end
    end
endmodule

// File: rtl/wcmd_parser_chk.sv
module wcmd_parser_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [7:0]  in_data,
    input logic        hdr_stb,
    input logic [23:0] hdr_len,
    input logic        dat_valid,
    input logic [7:0]  dat_byte,
    input logic        pkt_done,
    input logic [2:0]  pkt_code
);
    logic        in_body;
    logic [23:0] dcount;
    logic [23:0] len_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_body <= 1'b0;
            dcount  <= '0;
            len_lat <= '0;
        end else begin
            if (hdr_stb) begin
                in_body <= 1'b1;
                dcount  <= '0;
                len_lat <= hdr_len;
            end else if (dat_valid) begin
                dcount <= dcount + 1'b1;
            end
            if (pkt_done) in_body <= 1'b0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pkt_done && !hdr_stb && !dat_valid));

    // R12
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_done |-> pkt_code == 3'd0);

    // R6
    dat_echo_chk: assert property (@(posedge clk) disable iff (rst)
        dat_valid |-> ($past(in_valid) && dat_byte == $past(in_data)));

    // R6
    dat_in_body_chk: assert property (@(posedge clk) disable iff (rst)
        dat_valid |-> in_body);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdr_stb, dat_valid, pkt_done}));

    // R7
    len_match_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && pkt_code == 3'd0) |-> (in_body && dcount == len_lat));

    // R12
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> $past(in_valid));
endmodule

bind wcmd_parser wcmd_parser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .hdr_stb   (hdr_stb),
    .hdr_len   (hdr_len),
    .dat_valid (dat_valid),
    .dat_byte  (dat_byte),
    .pkt_done  (pkt_done),
    .pkt_code  (pkt_code)
);

// File: tb/tb_wcmd_parser.sv
module tb_wcmd_parser;
    localparam int EOP = 256;
    localparam int EEP = 257;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_eop = 1'b0;
    logic        in_eep = 1'b0;
    logic        hdr_stb;
    logic [15:0] hdr_tid;
    logic [7:0]  hdr_ext;
    logic [31:0] hdr_addr;
    logic [23:0] hdr_len;
    logic        dat_valid;
    logic [7:0]  dat_byte;
    logic        pkt_done;
    logic [2:0]  pkt_code;

    always #4 clk = ~clk;

    wcmd_parser dut (.*);

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    int pk[$];
    int txq[$];
    bit dropping = 0;
    bit          e_hdr, e_dv, e_done;
    logic [7:0]  e_db;
    logic [2:0]  e_code;
    logic [15:0] e_tid;
    logic [7:0]  e_ext;
    logic [31:0] e_addr;
    logic [23:0] e_len;

    function automatic logic [7:0] crc_span(input int q[$], input int a, input int b);
        logic [7:0] c = 8'h00;
        for (int i = a; i <= b; i++) begin
            c = c ^ q[i][7:0];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic string code_req(input logic [2:0] c);
        case (c)
            3'd0: return "R7";  3'd1: return "R5";  3'd2: return "R4";
            3'd3: return "R7";  3'd4: return "R9";  3'd5: return "R8";
            3'd6: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic model(input int ch);
        int pos, r, l;
        e_hdr = 0; e_dv = 0; e_done = 0; e_code = 0;
        if (ch < 0) return;
        if (dropping) begin
            if (ch >= 256) begin dropping = 0; pk.delete(); end
            return;
        end
        pos = pk.size();
        r = (pos > 2) ? 4 * (pk[2] & 3) : 0;   // R3 reply byte count
        l = (pos > 15 + r) ? ((pk[12+r] << 16) | (pk[13+r] << 8) | pk[14+r]) : 0;
        if (ch >= 256) begin
            e_done = 1;
            if (ch == EEP)               e_code = 5;
            else if (pos < 16 + r)       e_code = 4;
            else if (pos < 17 + r + l)   e_code = 6;
            else e_code = (crc_span(pk, 16 + r, 15 + r + l) == pk[16+r+l][7:0]) ? 3'd0 : 3'd3;
            pk.delete();
            return;
        end
        pk.push_back(ch);
        if (pos == 1 && ch != 1) begin
            e_done = 1; e_code = 1; dropping = 1;
        end else if (pos == 15 + r) begin
            if (crc_span(pk, 0, 14 + r) == ch[7:0]) begin
                e_hdr  = 1;
                e_tid  = {pk[5+r][7:0], pk[6+r][7:0]};
                e_ext  = pk[7+r][7:0];
                e_addr = {pk[8+r][7:0], pk[9+r][7:0], pk[10+r][7:0], pk[11+r][7:0]};
                e_len  = {pk[12+r][7:0], pk[13+r][7:0], pk[14+r][7:0]};
            end else begin
                e_done = 1; e_code = 2; dropping = 1;
            end
        end else if (pos > 15 + r && pos < 16 + r + l) begin
            e_dv = 1; e_db = ch[7:0];
        end else if (pos > 15 + r && pos == 17 + r + l) begin
            e_done = 1; e_code = 7; dropping = 1;
        end
    endtask

    task automatic compare();
        checks++;
        if (hdr_stb !== e_hdr || (e_hdr && (hdr_tid !== e_tid || hdr_ext !== e_ext ||
            hdr_addr !== e_addr || hdr_len !== e_len))) begin
            errors++;
            $display("FAIL R2 header: stb=%0b tid=%h ext=%h addr=%h len=%h expected stb=%0b tid=%h ext=%h addr=%h len=%h",
                     hdr_stb, hdr_tid, hdr_ext, hdr_addr, hdr_len, e_hdr, e_tid, e_ext, e_addr, e_len);
        end
        checks++;
        if (dat_valid !== e_dv || (e_dv && dat_byte !== e_db)) begin
            errors++;
            $display("FAIL R6 data: valid=%0b byte=%h expected valid=%0b byte=%h",
                     dat_valid, dat_byte, e_dv, e_db);
        end
        checks++;
        if (pkt_done !== e_done || pkt_code !== e_code) begin
            errors++;
            $display("FAIL %s/R12 outcome: done=%0b code=%0d expected done=%0b code=%0d",
                     code_req(e_code), pkt_done, pkt_code, e_done, e_code);
        end
    endtask

    task automatic cyc(input int ch);
        @(negedge clk);
        compare();
        in_valid = (ch >= 0);
        in_data  = (ch >= 0 && ch < 256) ? ch[7:0] : 8'h00;
        in_eop   = (ch == EOP);
        in_eep   = (ch == EEP);
        model(ch);
    endtask

    task automatic build(input int pid, input int r, input logic [15:0] tid, input logic [7:0] ext,
                         input logic [31:0] addr, input int len, input int ndata,
                         input bit bad_h, input bit bad_d, input int extra);
        int h0;
        logic [7:0] c;
        txq.delete();
        txq.push_back(8'hFE);
        txq.push_back(pid);
        txq.push_back(8'h6C | r);
        txq.push_back(8'h20);
        for (int i = 0; i < 4 * r; i++) txq.push_back(8'hA0 + i);
        txq.push_back(8'h42);
        txq.push_back(tid[15:8]); txq.push_back(tid[7:0]);
        txq.push_back(ext);
        txq.push_back(addr[31:24]); txq.push_back(addr[23:16]);
        txq.push_back(addr[15:8]);  txq.push_back(addr[7:0]);
        txq.push_back((len >> 16) & 255); txq.push_back((len >> 8) & 255); txq.push_back(len & 255);
        c = crc_span(txq, 0, txq.size() - 1);
        txq.push_back(bad_h ? (c ^ 8'h10) : c);
        h0 = txq.size();
        for (int i = 0; i < ndata; i++) txq.push_back((i * 37 + 5 + r) & 255);
        c = (ndata > 0) ? crc_span(txq, h0, txq.size() - 1) : 8'h00;
        txq.push_back(bad_d ? (c ^ 8'h01) : c);
        for (int i = 0; i < extra; i++) txq.push_back(8'h55 + i);
        txq.push_back(EOP);
    endtask

    task automatic send(input int gap);
        foreach (txq[i]) cyc(txq[i]);
        for (int i = 0; i < gap; i++) cyc(-1);
    endtask

    initial begin
        e_hdr = 0; e_dv = 0; e_done = 0; e_code = 0; e_db = 0;
        e_tid = 0; e_ext = 0; e_addr = 0; e_len = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (hdr_stb !== 0 || dat_valid !== 0 || pkt_done !== 0 || pkt_code !== 0) begin
            errors++;
            $display("FAIL R1 reset: stb=%0b dv=%0b done=%0b code=%0d expected all 0",
                     hdr_stb, dat_valid, pkt_done, pkt_code);
        end
        rst = 1'b0;
        cyc(-1); cyc(-1);

        // R2 R6 R7 plain write, no reply bytes
        build(1, 0, 16'h1234, 8'h0A, 32'hDEADBEEF, 4, 4, 0, 0, 0); send(2);
        // R3 reply bytes 8 and 12
        build(1, 2, 16'hBEEF, 8'h01, 32'h00010203, 3, 3, 0, 0, 0); send(1);
        build(1, 3, 16'h0001, 8'hFF, 32'h80000000, 6, 6, 0, 0, 0); send(1);
        // R7 zero length
        build(1, 1, 16'h4321, 8'h00, 32'h00000010, 0, 0, 0, 0, 0); send(1);
        // R5 bad protocol id
        build(2, 0, 16'h0002, 8'h00, 32'h0, 2, 2, 0, 0, 0); send(1);
        // R4 header CRC mismatch
        build(1, 1, 16'h0003, 8'h00, 32'h100, 2, 2, 1, 0, 0); send(1);
        // R7 data CRC mismatch
        build(1, 0, 16'h0004, 8'h00, 32'h200, 5, 5, 0, 1, 0); send(1);
        // R9 end inside header, and empty packet
        build(1, 0, 16'h0005, 8'h00, 32'h0, 2, 2, 0, 0, 0);
        txq = txq[0:5]; txq.push_back(EOP); send(1);
        txq.delete(); txq.push_back(EOP); send(1);
        // R8 error end inside data
        build(1, 0, 16'h0006, 8'h00, 32'h0, 6, 6, 0, 0, 0);
        txq = txq[0:18]; txq.push_back(EEP); send(1);
        // R8 error end inside header
        build(1, 2, 16'h0007, 8'h00, 32'h0, 2, 2, 0, 0, 0);
        txq = txq[0:7]; txq.push_back(EEP); send(1);
        // R10 fewer data bytes than length
        build(1, 0, 16'h0008, 8'h00, 32'h0, 5, 2, 0, 0, 0); send(1);
        // R11 extra bytes after data CRC
        build(1, 0, 16'h0009, 8'h00, 32'h0, 3, 3, 0, 0, 2); send(1);
        // R12 back-to-back packets with no gap
        build(1, 1, 16'hAAAA, 8'h11, 32'h12345678, 2, 2, 0, 0, 0); send(0);
        build(1, 0, 16'h5555, 8'h22, 32'h9ABCDEF0, 1, 1, 0, 0, 0); send(0);
        build(1, 0, 16'h6666, 8'h33, 32'h0, 7, 7, 0, 0, 0); send(3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule